// File: doc/BRIEF.md
# Dual-Channel Snapshot Capture Buffer

The block records two parallel converter channels into an on-chip memory, one sample pair per system clock, until the memory is full. It then freezes and keeps that single coherent frame until a host has read every word through a byte-oriented SPI slave port. Each stored word carries both channels. Every channel field holds its 14 data bits, an overflow flag and an even-parity bit, so the host can spot corrupted transfers.

Capture begins when the block is armed. If gating is enabled, it waits for a level trigger, so only the part of the signal that matters is stored. Reading the last word re-arms the block. A dedicated arm input discards the current frame at any time and restarts from address zero. The host may pause for any length of time between bytes while chip select stays low. It may also ask for the word just sent to be repeated, for example after a parity mismatch.

Top module: `dual_adc_snapshot`

## Requirements
- R1: Each 32-bit word is {chanA, chanB}: channel A in bits [31:16] and channel B in bits [15:0]. Each 16-bit field is {parity, overflow, data[13:0]}, with parity in the top bit.
- R2: The parity bit makes the number of ones across parity, overflow and the 14 data bits even.
- R3: After reset `bufFull` is 0 and `bufDrained` is 1. `spiMiso` is 0 whenever chip select has been high for two clock cycles.
- R4: While armed, capture starts at the first clock edge where the trigger condition holds (gating off, or `trigLevel` high). Word k holds the inputs present at the (k+1)-th rising edge after that edge.
- R5: With gating on and `trigLevel` low, the armed block stores nothing: `bufDrained` stays 1 and `bufFull` stays 0.
- R6: `bufFull` rises at the edge that writes the last address. From then on, input samples do not alter the stored frame.
- R7: Words go out in SPI mode 0 as four bytes, most significant byte first and most significant bit first. The read address advances after the fourth byte.
- R8: Any idle time between bytes with chip select held low leaves the read position unchanged.
- R9: Raising chip select in the middle of a word restarts that word at its first byte on the next selection, without advancing the address.
- R10: If `spiMosi` is high at the rising SCLK edge of the last bit of a word, that word is sent again instead of advancing.
- R11: Reading the final word drops `bufFull`, clears both pointers and re-arms the block (`bufDrained` = 1).
- R12: A high `armIn` at any clock edge discards the frame, clears both pointers and enters the armed state. With gating off, word 0 then holds the inputs at the second edge after the arm edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one sample pair per rising edge while capturing |
| rstN | input | 1 | Asynchronous active-low reset |
| adcAData | input | 14 | Channel A sample |
| adcAOvr | input | 1 | Channel A overflow flag |
| adcBData | input | 14 | Channel B sample |
| adcBOvr | input | 1 | Channel B overflow flag |
| armIn | input | 1 | Discard frame, clear pointers, re-arm |
| trigEn | input | 1 | 1: capture waits for `trigLevel`; 0: capture starts once armed |
| trigLevel | input | 1 | Level trigger |
| spiSclk | input | 1 | SPI clock from the host (idle low) |
| spiCsN | input | 1 | SPI chip select, active low |
| spiMosi | input | 1 | Host data; high on the last bit of a word requests a repeat |
| spiMiso | output | 1 | Serial read data |
| bufFull | output | 1 | A frozen frame is waiting to be read |
| bufDrained | output | 1 | Armed with no unread data |

## Verification
Status flags are due one edge after the event that causes them. `bufDrained` falls one edge after the trigger edge, and `bufFull` is high only after the edge that writes the last address. The bench therefore samples these flags at the falling edge just before and just after that edge. Stored words are due k+1 edges after the trigger edge, or k+2 after an arm edge. The bench drives a new sample at every falling edge and computes each expected word from the drive index. Serial bits settle within five clocks of a falling SCLK edge, so the bench holds each SCLK phase for eight clocks and samples MISO at the end of the low phase.

// File: rtl/snap_pkg.sv
package snap_pkg;

  localparam int DATA_W          = 14;
  localparam int CHAN_W          = DATA_W + 2;
  localparam int WORD_W          = 2 * CHAN_W;
  localparam int BYTE_W          = 8;
  localparam int BYTES_PER_WORD  = WORD_W / BYTE_W;
  localparam int BIT_CNT_W       = $clog2(BYTE_W);
  localparam int BYTE_CNT_W      = $clog2(BYTES_PER_WORD);
  localparam int SEL_W           = $clog2(WORD_W);

  typedef enum logic [1:0] {
    ST_ARMED   = 2'd0,
    ST_CAPTURE = 2'd1,
    ST_FULL    = 2'd2
  } snapState_e;

  // control -> datapath
  typedef struct packed {
    logic wrEn;
    logic rdInc;
    logic ptrClr;
  } snapStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic wrLast;
    logic rdLast;
    logic wordAdv;
  } snapStat_t;

  // {even parity, overflow, data}
  function automatic logic [CHAN_W-1:0] packChan(input logic [DATA_W-1:0] d,
                                                  input logic ovr);
    return {^{ovr, d}, ovr, d};
  endfunction

endpackage

// File: rtl/snap_mem.sv
module snap_mem #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 32,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) store[wrAddr] <= wrData;
    rdData <= store[rdAddr];
  end

endmodule

// File: rtl/snap_ctrl.sv
module snap_ctrl
  import snap_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        armIn,
  input  logic        trigEn,
  input  logic        trigLevel,
  input  snapStat_t   stat,
  output snapStrobe_t strobe,
  output logic        bufFull,
  output logic        bufDrained
);

  snapState_e state, nextState;

  always_comb begin
    nextState = state;
    strobe    = '0;
    if (armIn) begin
      strobe.ptrClr = 1'b1;
      nextState     = ST_ARMED;
    end else begin
      case (state)
        ST_ARMED: begin
          if (!trigEn || trigLevel) nextState = ST_CAPTURE;
        end
        ST_CAPTURE: begin
          strobe.wrEn = 1'b1;
          if (stat.wrLast) nextState = ST_FULL;
        end
        ST_FULL: begin
          if (stat.wordAdv) begin
            if (stat.rdLast) begin
              strobe.ptrClr = 1'b1;
              nextState     = ST_ARMED;
            end else begin
              strobe.rdInc = 1'b1;
            end
          end
        end
        default: nextState = ST_ARMED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_ARMED;
    else       state <= nextState;
  end

  assign bufFull    = (state == ST_FULL);
  assign bufDrained = (state == ST_ARMED);

endmodule

// File: rtl/snap_datapath.sv
module snap_datapath
  import snap_pkg::*;
#(
  parameter int ADDR_W = 11,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] adcAData,
  input  logic              adcAOvr,
  input  logic [DATA_W-1:0] adcBData,
  input  logic              adcBOvr,
  input  logic              spiSclk,
  input  logic              spiCsN,
  input  logic              spiMosi,
  input  snapStrobe_t       strobe,
  output snapStat_t         stat,
  output logic              spiMiso,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [WORD_W-1:0] wrWord
);

  localparam int       SYNC_LEN  = 2;
  localparam int       SYNC_BITS = 3;
  localparam logic [SYNC_BITS-1:0] SYNC_RST = 3'b010;  // sclk low, cs high, mosi low

  // ---------------- input synchronisers ----------------
  logic [SYNC_BITS-1:0] rawIn, syncOut;
  assign rawIn = {spiSclk, spiCsN, spiMosi};

  for (genvar g = 0; g < SYNC_BITS; g++) begin : gSync
    logic [SYNC_LEN-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= {SYNC_LEN{SYNC_RST[g]}};
      else       chain <= {chain[SYNC_LEN-2:0], rawIn[g]};
    end
    assign syncOut[g] = chain[SYNC_LEN-1];
  end

  logic sclkS, csS, mosiS, sclkQ;
  assign sclkS = syncOut[2];
  assign csS   = syncOut[1];
  assign mosiS = syncOut[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkQ <= 1'b0;
    else       sclkQ <= sclkS;
  end

  logic csActive, sclkRise, sclkFall;
  assign csActive = ~csS;
  assign sclkRise = sclkS & ~sclkQ;
  assign sclkFall = ~sclkS & sclkQ;

  // ---------------- serial position ----------------
  logic [BIT_CNT_W-1:0]  bitCnt;
  logic [BYTE_CNT_W-1:0] byteCnt;
  logic                  repeatReq;
  logic                  lastBit;

  assign lastBit = (bitCnt == BIT_CNT_W'(BYTE_W - 1)) &&
                   (byteCnt == BYTE_CNT_W'(BYTES_PER_WORD - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      byteCnt   <= '0;
      repeatReq <= 1'b0;
    end else if (!csActive) begin
      bitCnt    <= '0;
      byteCnt   <= '0;
      repeatReq <= 1'b0;
    end else if (sclkRise) begin
      if (lastBit) repeatReq <= mosiS;
    end else if (sclkFall) begin
      bitCnt <= bitCnt + 1'b1;
      if (bitCnt == BIT_CNT_W'(BYTE_W - 1)) byteCnt <= byteCnt + 1'b1;
      if (lastBit) repeatReq <= 1'b0;
    end
  end

  logic wordDone;
  assign wordDone     = csActive & sclkFall & lastBit;
  assign stat.wordAdv = wordDone & ~repeatReq;
  assign stat.wrLast  = (wrAddr == ADDR_W'(DEPTH - 1));
  assign stat.rdLast  = (rdAddr == ADDR_W'(DEPTH - 1));

  // ---------------- pointers ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrAddr <= '0;
      rdAddr <= '0;
    end else if (strobe.ptrClr) begin
      wrAddr <= '0;
      rdAddr <= '0;
    end else begin
      if (strobe.wrEn)  wrAddr <= wrAddr + 1'b1;
      if (strobe.rdInc) rdAddr <= rdAddr + 1'b1;
    end
  end

  // ---------------- storage ----------------
  assign wrWord = {packChan(adcAData, adcAOvr), packChan(adcBData, adcBOvr)};

  logic [WORD_W-1:0] rdData;

  snap_mem #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) uMem (
    .clk    (clk),
    .wrEn   (strobe.wrEn),
    .wrAddr (wrAddr),
    .wrData (wrWord),
    .rdAddr (rdAddr),
    .rdData (rdData)
  );

  // MSB byte first, MSB bit first: index = WORD_W-1 - position
  logic [SEL_W-1:0] bitSel;
  assign bitSel  = ~{byteCnt, bitCnt};
  assign spiMiso = csActive & rdData[bitSel];

endmodule

// File: rtl/dual_adc_snapshot.sv
module dual_adc_snapshot
  import snap_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] adcAData,
  input  logic              adcAOvr,
  input  logic [DATA_W-1:0] adcBData,
  input  logic              adcBOvr,
  input  logic              armIn,
  input  logic              trigEn,
  input  logic              trigLevel,
  input  logic              spiSclk,
  input  logic              spiCsN,
  input  logic              spiMosi,
  output logic              spiMiso,
  output logic              bufFull,
  output logic              bufDrained
);

  snapStrobe_t       strobe;
  snapStat_t         stat;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic [WORD_W-1:0] wrWord;

  snap_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .armIn      (armIn),
    .trigEn     (trigEn),
    .trigLevel  (trigLevel),
    .stat       (stat),
    .strobe     (strobe),
    .bufFull    (bufFull),
    .bufDrained (bufDrained)
  );

  snap_datapath #(.ADDR_W(ADDR_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .adcAData (adcAData),
    .adcAOvr  (adcAOvr),
    .adcBData (adcBData),
    .adcBOvr  (adcBOvr),
    .spiSclk  (spiSclk),
    .spiCsN   (spiCsN),
    .spiMosi  (spiMosi),
    .strobe   (strobe),
    .stat     (stat),
    .spiMiso  (spiMiso),
    .wrAddr   (wrAddr),
    .rdAddr   (rdAddr),
    .wrWord   (wrWord)
  );

endmodule

// File: rtl/snap_checks.sv
module snap_checks
  import snap_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              armIn,
  input logic              trigEn,
  input logic              trigLevel,
  input logic              spiCsN,
  input logic              spiMiso,
  input logic              bufFull,
  input logic              bufDrained,
  input snapStrobe_t       strobe,
  input snapStat_t         stat,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [WORD_W-1:0] wrWord
);

  // R2: every stored field has even parity
  p_even_parity_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |-> (^wrWord[WORD_W-1:CHAN_W] == 1'b0) && (^wrWord[CHAN_W-1:0] == 1'b0));

  // R3: MISO quiet once chip select has been high long enough
  p_miso_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    $past(spiCsN, 2) |-> !spiMiso);

  // R4: each capture cycle moves the write pointer by one
  p_wr_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |=> wrAddr == ADDR_W'($past(wrAddr) + 1'b1));

  // R5: gated and untriggered, the block stays armed
  p_holdoff_r5: assert property (@(posedge clk) disable iff (!rstN)
    bufDrained && trigEn && !trigLevel && !armIn |=> bufDrained && !bufFull);

  // R6: a frozen frame is never written
  p_no_write_full_r6: assert property (@(posedge clk) disable iff (!rstN)
    bufFull |-> !strobe.wrEn);

  // R6: frame stays frozen until a word completes or arm arrives
  p_full_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    bufFull && !armIn && !stat.wordAdv |=> bufFull);

  // R7: a completed word advances the read pointer
  p_rd_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    bufFull && stat.wordAdv && !stat.rdLast && !armIn |=> rdAddr == ADDR_W'($past(rdAddr) + 1'b1));

  // R11: the final word re-arms with cleared pointers
  p_drain_rearm_r11: assert property (@(posedge clk) disable iff (!rstN)
    bufFull && stat.wordAdv && stat.rdLast && !armIn |=> bufDrained && rdAddr == '0 && wrAddr == '0);

  // R12: arm clears both pointers
  p_arm_clear_r12: assert property (@(posedge clk) disable iff (!rstN)
    armIn |=> bufDrained && rdAddr == '0 && wrAddr == '0);

endmodule

bind dual_adc_snapshot snap_checks #(.ADDR_W(ADDR_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .armIn      (armIn),
  .trigEn     (trigEn),
  .trigLevel  (trigLevel),
  .spiCsN     (spiCsN),
  .spiMiso    (spiMiso),
  .bufFull    (bufFull),
  .bufDrained (bufDrained),
  .strobe     (strobe),
  .stat       (stat),
  .wrAddr     (wrAddr),
  .rdAddr     (rdAddr),
  .wrWord     (wrWord)
);

// File: tb/dual_adc_snapshot_test.sv
module dual_adc_snapshot_test;

  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int HALF   = 8;

  // stimulus vectors: bit 14 = overflow, bits 13:0 = data
  localparam logic [14:0] VEC_A [16] = '{
    15'h0000, 15'h3FFF, 15'h7FFF, 15'h4000, 15'h0001, 15'h2AAA, 15'h1555, 15'h5A5A,
    15'h0F0F, 15'h7001, 15'h0100, 15'h3C3C, 15'h6666, 15'h0003, 15'h1234, 15'h4321};
  localparam logic [14:0] VEC_B [16] = '{
    15'h7FFF, 15'h0000, 15'h4001, 15'h3FFE, 15'h2000, 15'h5555, 15'h0AAA, 15'h0707,
    15'h4F00, 15'h0011, 15'h7F80, 15'h0042, 15'h1999, 15'h6000, 15'h2468, 15'h0F1E};

  logic        clk = 1'b0, rstN = 1'b0;
  logic [13:0] adcAData = '0, adcBData = '0;
  logic        adcAOvr = 1'b0, adcBOvr = 1'b0;
  logic        armIn = 1'b0, trigEn = 1'b1, trigLevel = 1'b0;
  logic        spiSclk = 1'b0, spiCsN = 1'b1, spiMosi = 1'b0;
  logic        spiMiso, bufFull, bufDrained;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  dual_adc_snapshot #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rstN(rstN),
    .adcAData(adcAData), .adcAOvr(adcAOvr), .adcBData(adcBData), .adcBOvr(adcBOvr),
    .armIn(armIn), .trigEn(trigEn), .trigLevel(trigLevel),
    .spiSclk(spiSclk), .spiCsN(spiCsN), .spiMosi(spiMosi),
    .spiMiso(spiMiso), .bufFull(bufFull), .bufDrained(bufDrained));

  function automatic logic [15:0] chanExp(input logic [14:0] v);
    int ones = 0;
    for (int i = 0; i < 15; i++) ones += int'(v[i]);
    return {ones % 2 == 1, v[14], v[13:0]};
  endfunction

  function automatic logic [31:0] wordExp(input logic [14:0] a, input logic [14:0] b);
    return {chanExp(a), chanExp(b)};
  endfunction

  function automatic logic [14:0] gA(input int i); return {i[0], 14'(i * 37)}; endfunction
  function automatic logic [14:0] gB(input int i); return {i[1], 14'(16383 - i)}; endfunction
  function automatic logic [14:0] hA(input int i); return {i[2], 14'(i * 101 + 5)}; endfunction
  function automatic logic [14:0] hB(input int i); return {~i[0], 14'(i << 3)}; endfunction

  task automatic drive(input logic [14:0] a, input logic [14:0] b);
    adcAOvr = a[14]; adcAData = a[13:0];
    adcBOvr = b[14]; adcBData = b[13:0];
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic csOn();
    spiCsN = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic csOff();
    spiCsN = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic readByte(input logic repeatLast, output logic [7:0] v);
    for (int k = 7; k >= 0; k--) begin
      v[k]    = spiMiso;
      spiMosi = repeatLast && (k == 0);
      spiSclk = 1'b1;
      repeat (HALF) @(negedge clk);
      spiSclk = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    spiMosi = 1'b0;
  endtask

  task automatic readWord(input logic repeatLast, input int gap, output logic [31:0] w);
    logic [7:0] v;
    w = '0;
    for (int b = 0; b < 4; b++) begin
      readByte(repeatLast && (b == 3), v);
      w = {w[23:0], v};
      repeat (gap) @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    finishRun();
  end

  initial begin
    logic [31:0] w;
    logic [7:0]  v;

    // ---- reset (R3)
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R3 full after reset", 32'(bufFull), 32'd0);
    check("R3 drained after reset", 32'(bufDrained), 32'd1);
    check("R3 miso idle", 32'(spiMiso), 32'd0);

    // ---- hold-off (R5)
    repeat (20) @(negedge clk);
    check("R5 no capture while untriggered", 32'(bufDrained), 32'd1);
    check("R5 not full while untriggered", 32'(bufFull), 32'd0);

    // ---- triggered capture of the vector table (R4, R6)
    for (int i = 0; i <= 26; i++) begin
      if (i == 1)  check("R4 capture starts after trigger", 32'(bufDrained), 32'd0);
      if (i == 16) check("R6 not full before last write", 32'(bufFull), 32'd0);
      if (i == 17) check("R6 full at last write", 32'(bufFull), 32'd1);
      if (i == 0) trigLevel = 1'b1;
      if (i == 2) trigLevel = 1'b0;
      if (i <= 16) drive(VEC_A[(i + 15) % 16], VEC_B[(i + 15) % 16]);
      else         drive(15'h7FFF, 15'h7FFF);
      @(negedge clk);
    end

    // ---- readout (R1, R2, R7, R8, R9, R10)
    csOn();
    readWord(1'b0, 40, w);
    check("R8 R1 R2 word0 with byte gaps", w, wordExp(VEC_A[0], VEC_B[0]));
    readWord(1'b0, 0, w);
    check("R7 word1", w, wordExp(VEC_A[1], VEC_B[1]));
    readByte(1'b0, v);
    check("R7 first byte of word2", 32'(v), 32'(wordExp(VEC_A[2], VEC_B[2]) >> 24));
    csOff();
    csOn();
    readWord(1'b0, 0, w);
    check("R9 word2 restarts after deselect", w, wordExp(VEC_A[2], VEC_B[2]));
    readWord(1'b1, 0, w);
    check("R10 word3 first send", w, wordExp(VEC_A[3], VEC_B[3]));
    readWord(1'b0, 0, w);
    check("R10 word3 repeated", w, wordExp(VEC_A[3], VEC_B[3]));
    for (int k = 4; k < DEPTH; k++) begin
      if (k == DEPTH - 1) check("R11 full before final word", 32'(bufFull), 32'd1);
      readWord(1'b0, 0, w);
      check("R6 R1 R2 stored word unchanged", w, wordExp(VEC_A[k], VEC_B[k]));
    end
    csOff();
    check("R11 full cleared after drain", 32'(bufFull), 32'd0);
    check("R11 re-armed after drain", 32'(bufDrained), 32'd1);

    // ---- ungated capture after drain (R4, R11)
    for (int i = 0; i <= 20; i++) begin
      if (i == 0) trigEn = 1'b0;
      drive(gA(i), gB(i));
      @(negedge clk);
    end
    check("R4 ungated capture full", 32'(bufFull), 32'd1);
    csOn();
    readWord(1'b0, 0, w);
    check("R11 R4 word0 after re-arm", w, wordExp(gA(1), gB(1)));
    readWord(1'b0, 0, w);
    check("R4 word1 after re-arm", w, wordExp(gA(2), gB(2)));
    csOff();

    // ---- arm while a frame is pending (R12)
    for (int i = 0; i <= 20; i++) begin
      if (i == 1) begin
        check("R12 arm drops full", 32'(bufFull), 32'd0);
        check("R12 arm re-arms", 32'(bufDrained), 32'd1);
      end
      if (i == 17) check("R12 not full before last write", 32'(bufFull), 32'd0);
      if (i == 18) check("R12 full at last write", 32'(bufFull), 32'd1);
      armIn = (i == 0);
      drive(hA(i), hB(i));
      @(negedge clk);
    end
    csOn();
    readWord(1'b0, 0, w);
    check("R12 read pointer cleared by arm", w, wordExp(hA(2), hB(2)));
    readWord(1'b0, 0, w);
    check("R12 word1 after arm", w, wordExp(hA(3), hB(3)));
    csOff();
    check("R3 miso idle after deselect", 32'(spiMiso), 32'd0);

    finishRun();
  end

endmodule